// File: doc/BRIEF.md
# Flash Controller Interrupt Status and Enable Unit

This unit holds the interrupt state of a serial flash controller that sits on a simple register bus. Six FIFO condition flags come in from the surrounding FIFO logic. The unit captures them into a status register. Software acknowledges an event by reading the status and writing the same value back, because a one written to a status bit clears it.

The enable mask cannot be written directly. Software changes it only by writing ones to a write-only set register or to a write-only clear register. It reads the mask back from a separate read-only register. One registered, level-sensitive interrupt line is high whenever an enabled status bit is set.

Two kinds of bit share the status word. The overflow and underflow bits are sticky: they stay set until software clears them. The threshold and full bits follow the live FIFO condition on every cycle.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the sticky status bits are 0, the enable mask is 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: The status, enable-set, enable-clear and mask registers share one bit layout. Bit 0 is receive overflow, bit 2 is transmit below threshold, bit 3 is transmit full, bit 4 is receive at or above threshold, bit 5 is receive full and bit 6 is transmit underflow. Bit 1 and all bits above 6 read as 0. The event input `evt_i` uses the same layout.
- R3: The sticky bits 0 and 6 are set at the clock edge that samples the event input high. They stay set until a write of one clears them.
- R4: Status bits 2 to 5 equal the event input sampled at the previous clock edge. Writes to the status register have no effect on them.
- R5: A bus write to offset 0x04 clears each sticky bit whose write-data bit is 1. Sticky bits whose write-data bit is 0 keep their value.
- R6: When a clearing write and a new event hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x08 enables every implemented source whose data bit is 1. Zero bits leave the mask unchanged.
- R8: A write to offset 0x0C disables every source whose data bit is 1. Zero bits leave the mask unchanged.
- R9: A read of offset 0x10 returns the mask. Reads of 0x08, 0x0C and any unmapped offset return 0. Writes to 0x10 do not change the mask.
- R10: `irq_o` is high exactly when some status bit and its mask bit are both set. It updates at the same clock edge as the status and mask registers.
- R11: A read request (`bus_sel`=1, `bus_we`=0) returns its data on `bus_rdata` after the next clock edge. The data reflects the registers as they stood before that edge. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_i | input | 7 | FIFO event flags, in the status bit layout |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clearing write and a fresh event landing on the same sticky bit in the same cycle. The bench raises the event input in exactly the cycle that drives the write-one-to-clear onto the bus. The other awkward case is a status write that includes the live-bit positions while those FIFO flags are held high; this shows that the write cannot disturb the live bits. In both cases the result is read back over the bus, and `irq_o` is compared with a behavioural model on every clock.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int SRC_W = 7;
  localparam logic [SRC_W-1:0] STICKY_BITS = 7'b100_0001;
  localparam logic [SRC_W-1:0] LIVE_BITS   = 7'b011_1100;
  localparam logic [SRC_W-1:0] IMPL_BITS   = STICKY_BITS | LIVE_BITS;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_EN_SET = 'h08;
  localparam int OFF_EN_CLR = 'h0C;
  localparam int OFF_MASK   = 'h10;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [SRC_W-1:0]  status_i,
  input  logic [SRC_W-1:0]  mask_i,
  output logic              wr_status_o,
  output logic              wr_set_o,
  output logic              wr_clr_o,
  output logic [SRC_W-1:0]  wbits_o,
  output logic [DATA_W-1:0] rdata_o
);
  import flash_irq_pkg::*;

  logic rd_req;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SRC_W];
  assign wbits_o     = bus_wdata[SRC_W-1:0];
  assign rd_req      = bus_sel && !bus_we;
  assign wr_status_o = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
  assign wr_set_o    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_EN_SET));
  assign wr_clr_o    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_EN_CLR));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_req) begin
      if (bus_addr == ADDR_W'(OFF_STATUS))
        rdata_o <= DATA_W'(status_i);
      else if (bus_addr == ADDR_W'(OFF_MASK))
        rdata_o <= DATA_W'(mask_i);
      else
        rdata_o <= '0;
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int               SRC_W  = 7,
  parameter logic [SRC_W-1:0] STICKY = '0,
  parameter logic [SRC_W-1:0] LIVE   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] evt_i,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] status_o,
  output logic [SRC_W-1:0] status_nxt_o
);
  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      // a new event outranks a simultaneous clear
      assign status_nxt_o[b] = evt_i[b] ? 1'b1 :
                               (clr_en && clr_bits[b]) ? 1'b0 : status_o[b];
    end else if (LIVE[b]) begin : g_live
      assign status_nxt_o[b] = evt_i[b];
    end else begin : g_none
      assign status_nxt_o[b] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) status_o[b] <= 1'b0;
      else     status_o[b] <= status_nxt_o[b];
    end
  end
endmodule

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
  parameter int               SRC_W = 7,
  parameter logic [SRC_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] bits_i,
  output logic [SRC_W-1:0] mask_o,
  output logic [SRC_W-1:0] mask_nxt_o
);
  always_comb begin
    mask_nxt_o = mask_o;
    if (set_en) mask_nxt_o = mask_nxt_o | (bits_i & IMPL);
    if (clr_en) mask_nxt_o = mask_nxt_o & ~bits_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else     mask_o <= mask_nxt_o;
  end
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_sel,
  input  logic                            bus_we,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [flash_irq_pkg::SRC_W-1:0] evt_i,
  output logic                            irq_o
);
  import flash_irq_pkg::*;

  logic             wr_status, wr_set, wr_clr;
  logic [SRC_W-1:0] wbits;
  logic [SRC_W-1:0] status_q, status_nxt;
  logic [SRC_W-1:0] mask_q, mask_nxt;

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_dec (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_i(status_q), .mask_i(mask_q),
    .wr_status_o(wr_status), .wr_set_o(wr_set), .wr_clr_o(wr_clr),
    .wbits_o(wbits), .rdata_o(bus_rdata)
  );

  irq_status_reg #(.SRC_W(SRC_W), .STICKY(STICKY_BITS), .LIVE(LIVE_BITS)) u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr_en(wr_status), .clr_bits(wbits),
    .status_o(status_q), .status_nxt_o(status_nxt)
  );

  irq_enable_mask #(.SRC_W(SRC_W), .IMPL(IMPL_BITS)) u_mask (
    .clk(clk), .rst(rst), .set_en(wr_set), .clr_en(wr_clr),
    .bits_i(wbits), .mask_o(mask_q), .mask_nxt_o(mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_nxt & mask_nxt);
  end
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [6:0]        evt_i,
  input logic [6:0]        status_q,
  input logic [6:0]        mask_q,
  input logic              irq_o
);
  logic st_wr, set_wr, clr_wr;
  assign st_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'('h04));
  assign set_wr = bus_sel && bus_we && (bus_addr == ADDR_W'('h08));
  assign clr_wr = bus_sel && bus_we && (bus_addr == ADDR_W'('h0C));

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & mask_q));

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !(st_wr && bus_wdata[0])) |=> status_q[0]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_i[0] || evt_i[6]) |=> ((status_q[0] || !$past(evt_i[0])) && (status_q[6] || !$past(evt_i[6]))));

  assert_live_follow_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[5:2] == $past(evt_i[5:2])));

  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((mask_q & ($past(bus_wdata[6:0]) & 7'h7D)) == ($past(bus_wdata[6:0]) & 7'h7D)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((mask_q & $past(bus_wdata[6:0])) == 7'h00));

  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !(set_wr || clr_wr) |=> $stable(mask_q));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !status_q[1] && !mask_q[1]);
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_i(evt_i),
  .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/flash_irq_ctrl_tb_top.sv
module flash_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [6:0] evt_idle = '0;

  // behavioural reference state
  bit [6:0]  m_st, m_mk;
  bit        m_irq;
  bit [31:0] m_rd;

  always #5 clk = ~clk;

  flash_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    bit [6:0] ns, nm;
    if (rst) begin
      m_st = 0; m_mk = 0; m_irq = 0; m_rd = 0;
    end else begin
      if (bus_sel && !bus_we)
        m_rd = (bus_addr == 8'h04) ? {25'b0, m_st} :
               (bus_addr == 8'h10) ? {25'b0, m_mk} : 32'b0;
      ns = 0;
      for (int b = 0; b < 7; b++) begin
        if (b == 0 || b == 6) begin
          if (evt_i[b]) ns[b] = 1;
          else if (bus_sel && bus_we && bus_addr == 8'h04 && bus_wdata[b]) ns[b] = 0;
          else ns[b] = m_st[b];
        end else if (b >= 2 && b <= 5) begin
          ns[b] = evt_i[b];
        end
      end
      nm = m_mk;
      if (bus_sel && bus_we && bus_addr == 8'h08) nm = nm | (bus_wdata[6:0] & 7'h7D);
      if (bus_sel && bus_we && bus_addr == 8'h0C) nm = nm & ~bus_wdata[6:0];
      m_st = ns; m_mk = nm;
      m_irq = |(ns & nm);
    end
  end

  // interrupt line compared every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq_o !== m_irq) begin
        fails++;
        $display("FAIL R10 irq_o actual %0b expected %0b at %0t", irq_o, m_irq, $time);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [6:0] ev);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; evt_i = evt_idle;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; evt_i = evt_idle;
    @(negedge clk);
    bus_sel = 0;
    checks++;
    if (bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s read 0x%02h actual 0x%08h expected 0x%08h", tag, a, bus_rdata, m_rd);
    end
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = evt_idle;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    checks++;
    if (bus_rdata !== 32'h0 || irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 rdata/irq actual %h/%b expected 0/0", bus_rdata, irq_o);
    end
    bus_rd(8'h04, "R1 status");
    bus_rd(8'h10, "R1 mask");
    // R3: sticky overflow capture
    pulse(7'h01);
    repeat (2) @(negedge clk);
    bus_rd(8'h04, "R3 sticky bit0");
    bus_wr(8'h08, 32'h1, evt_idle);                // R7 enable bit0 -> irq
    bus_rd(8'h10, "R7 mask set bit0");
    bus_wr(8'h04, 32'h40, evt_idle);               // R5 zero bit leaves bit0
    bus_rd(8'h04, "R5 unrelated clear");
    bus_wr(8'h04, 32'h01, evt_idle);               // R5 clear bit0
    bus_rd(8'h04, "R5 cleared");
    // R4: live bits
    evt_idle = 7'h3C;
    @(negedge clk) evt_i = evt_idle;
    bus_rd(8'h04, "R4 live all");
    bus_wr(8'h04, 32'hFFFF_FFFF, evt_idle);
    bus_rd(8'h04, "R4 live after write");
    evt_idle = 7'h14;
    @(negedge clk) evt_i = evt_idle;
    bus_rd(8'h04, "R4 live pattern");
    bus_wr(8'h08, 32'h10, evt_idle);               // R10 live-driven irq
    evt_idle = 7'h00;
    @(negedge clk) evt_i = evt_idle;
    @(negedge clk);
    // R6: event beats simultaneous clear
    pulse(7'h40);
    bus_wr(8'h04, 32'h40, 7'h40);
    bus_rd(8'h04, "R6 event wins");
    bus_wr(8'h04, 32'h40, evt_idle);
    bus_rd(8'h04, "R6 later clear");
    // R7/R8/R9 mask paths
    bus_wr(8'h08, 32'hFFFF_FFFF, evt_idle);
    bus_rd(8'h10, "R7 set all implemented");
    bus_wr(8'h0C, 32'h3C, evt_idle);
    bus_rd(8'h10, "R8 clear live bits");
    bus_wr(8'h0C, 32'h0, evt_idle);
    bus_rd(8'h10, "R8 zero clear no effect");
    bus_wr(8'h08, 32'h0, evt_idle);
    bus_rd(8'h10, "R7 zero set no effect");
    bus_wr(8'h10, 32'h0, evt_idle);
    bus_rd(8'h10, "R9 mask not writable");
    bus_rd(8'h08, "R9 set reg reads zero");
    bus_rd(8'h0C, "R9 clear reg reads zero");
    bus_rd(8'h14, "R9 unmapped reads zero");
    // R2 layout / R11 hold: reserved bit 1 event never shows
    pulse(7'h02);
    bus_rd(8'h04, "R2 reserved bit");
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL R11 rdata hold actual %h expected %h", bus_rdata, m_rd);
    end
    pulse(7'h41);                                   // R10 with mask 0x41
    bus_wr(8'h0C, 32'h41, evt_idle);
    bus_wr(8'h04, 32'h41, evt_idle);
    bus_rd(8'h04, "R5 both sticky cleared");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule